// File: doc/BRIEF.md
# Serial Link Error Supervisor

This block sits beside the bit decoder and protocol engine of a J1850-style serial data link. It takes one-cycle error and bus-event strobes and sorts them into three error classes: invalid symbol, transmit mismatch and CRC error. It keeps a pending flag for each class and shows the highest-coded pending class as a state-vector code with an interrupt line. A host read removes the code on display. A later error is never lost while an earlier code is still unread.

The block also drives the link's recovery. Each class has its own path. Invalid-symbol conditions are a received break, a bad bit, a framing error or a physical-layer fault. They stop the link until the bus is idle and then until a start-of-frame. A transmit mismatch aborts the transmitter and blocks new transmissions until the bus is idle. A CRC error suspends reception until the next start-of-frame. The block can only observe breaks and never produces one.

Top module: `link_fault_supervisor`

## Requirements
- R1: After a synchronous active-high reset the outputs are: `rec_state` = 1 (wait-idle), `vec_code` = 0, `irq` = 0, `tx_abort` = 0, `tx_inhibit` = 1 and `rx_enable` = 0.
- R2: A break strobe while `is_tx` or `is_rx` is high sets the invalid-symbol class (code 0x1C) and moves `rec_state` to 1 after the clock edge. A break while both are low changes nothing.
- R3: Recovery states are encoded 0 normal, 1 wait-idle, 2 wait-SOF and 3 inhibit-TX. Wait-idle goes to wait-SOF on `bus_idle`. Wait-SOF goes to normal on `sof_seen`. A start-of-frame seen in wait-idle is ignored.
- R4: A CRC strobe sets the CRC class (code 0x14) and moves the recovery state to wait-SOF. It does not raise `tx_abort`.
- R5: A bad-bit or framing strobe sets code 0x1C and moves the state to wait-idle. `tx_abort` goes high for one cycle if `is_tx` was high.
- R6: A transmit mismatch sets code 0x18, pulses `tx_abort` in the next cycle and moves the state to inhibit-TX. Inhibit-TX returns to normal on `bus_idle`.
- R7: A physical-layer fault strobe reports code 0x1C and moves the state to wait-idle.
- R8: When several classes are pending, `vec_code` shows the highest code. `irq` is high exactly when `vec_code` is non-zero.
- R9: A `host_rd` pulse clears only the class on display. The next pending class then appears, or 0 with `irq` low if none remains.
- R10: An error that arrives in the same cycle as `host_rd` stays pending, even if it is the class being cleared.
- R11: When error strobes coincide, recovery follows the strictest one: invalid symbol before transmit mismatch before CRC.
- R12: `tx_inhibit` is high in wait-idle and inhibit-TX. `rx_enable` is high in normal and inhibit-TX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_break | input | 1 | Break symbol received (strobe) |
| ev_bad_bit | input | 1 | Invalid bit off a byte boundary (strobe) |
| ev_frame_err | input | 1 | Framing symbol off a byte boundary (strobe) |
| ev_crc_err | input | 1 | CRC mismatch at end of frame (strobe) |
| ev_tx_mismatch | input | 1 | Read-back bit differs from sent bit (strobe) |
| ev_phy_fault | input | 1 | Physical-layer fault such as a bus short (strobe) |
| bus_idle | input | 1 | Bus idle detected |
| sof_seen | input | 1 | Valid start-of-frame detected |
| is_tx | input | 1 | Link is transmitting |
| is_rx | input | 1 | Link is receiving |
| host_rd | input | 1 | Host reads the state vector (strobe) |
| vec_code | output | CODE_W | Highest pending state-vector code |
| irq | output | 1 | Interrupt, some class pending |
| tx_abort | output | 1 | One-cycle abort to the transmitter |
| tx_inhibit | output | 1 | Transmission start not allowed |
| rx_enable | output | 1 | Reception accepted |
| rec_state | output | 2 | Recovery state |

## Verification
A host read can fall in the same cycle as a new error strobe. The read clears one pending class while the strobe sets a class that may be the same one. Error strobes can also coincide with `bus_idle` or `sof_seen`, so an advance of the recovery state competes with a new error. The bench provokes both with a full sweep of every combination of the eleven strobe and status inputs, run twice in different orders. After each edge it compares every output against a bench model built from the requirements. That model clears before it sets and gives errors precedence over recovery progress.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
   typedef enum logic [1:0] {
      ST_NORMAL     = 2'd0,
      ST_WAIT_IDLE  = 2'd1,
      ST_WAIT_SOF   = 2'd2,
      ST_INHIBIT_TX = 2'd3
   } rec_state_e;

   localparam int NUM_CLASS = 3;
   localparam int CLS_CRC   = 0;
   localparam int CLS_ARB   = 1;
   localparam int CLS_INV   = 2;
endpackage

// File: rtl/lfs_classify.sv
module lfs_classify
   import lfs_pkg::*;
#(
   parameter bit BREAK_ANY_TIME = 1'b0
) (
   input  logic                 ev_break,
   input  logic                 ev_bad_bit,
   input  logic                 ev_frame_err,
   input  logic                 ev_crc_err,
   input  logic                 ev_tx_mismatch,
   input  logic                 ev_phy_fault,
   input  logic                 is_tx,
   input  logic                 is_rx,
   output logic [NUM_CLASS-1:0] cls_hit,
   output logic                 abort_req
);
   logic brk_valid;

   generate
      if (BREAK_ANY_TIME) begin : g_brk_any
         logic unused_act;
         assign unused_act = is_rx;
         assign brk_valid  = ev_break;
      end else begin : g_brk_active
         assign brk_valid = ev_break & (is_tx | is_rx);
      end
   endgenerate

   always_comb begin
      cls_hit          = '0;
      cls_hit[CLS_INV] = brk_valid | ev_bad_bit | ev_frame_err | ev_phy_fault;
      cls_hit[CLS_ARB] = ev_tx_mismatch;
      cls_hit[CLS_CRC] = ev_crc_err;
   end

   assign abort_req = ev_tx_mismatch | (is_tx & cls_hit[CLS_INV]);
endmodule

// File: rtl/lfs_vector.sv
module lfs_vector
   import lfs_pkg::*;
#(
   parameter int CODE_W   = 8,
   parameter int CODE_CRC = 'h14,
   parameter int CODE_ARB = 'h18,
   parameter int CODE_INV = 'h1C
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_CLASS-1:0] cls_hit,
   input  logic                 host_rd,
   output logic [CODE_W-1:0]    vec_code,
   output logic                 irq
);
   localparam logic [CODE_W-1:0] CODES [NUM_CLASS] = '{
      CODE_W'(CODE_CRC), CODE_W'(CODE_ARB), CODE_W'(CODE_INV)};

   logic [NUM_CLASS-1:0] pend;
   logic [NUM_CLASS-1:0] shown;
   logic [CODE_W-1:0]    best;

   always_comb begin
      best  = '0;
      shown = '0;
      for (int i = 0; i < NUM_CLASS; i++) begin
         if (pend[i] && (CODES[i] > best)) begin
            best     = CODES[i];
            shown    = '0;
            shown[i] = 1'b1;
         end
      end
   end

   generate
      for (genvar g = 0; g < NUM_CLASS; g++) begin : g_cell
         logic q;
         always_ff @(posedge clk) begin
            if (rst)                    q <= 1'b0;
            else if (cls_hit[g])        q <= 1'b1;
            else if (host_rd && shown[g]) q <= 1'b0;
         end
         assign pend[g] = q;
      end
   endgenerate

   assign vec_code = best;
   assign irq      = |pend;
endmodule

// File: rtl/lfs_recovery.sv
module lfs_recovery
   import lfs_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       inv_hit,
   input  logic       arb_hit,
   input  logic       crc_hit,
   input  logic       bus_idle,
   input  logic       sof_seen,
   output rec_state_e state,
   output logic       tx_inhibit,
   output logic       rx_enable
);
   rec_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_WAIT_IDLE:  if (bus_idle) nxt = ST_WAIT_SOF;
         ST_WAIT_SOF:   if (sof_seen) nxt = ST_NORMAL;
         ST_INHIBIT_TX: if (bus_idle) nxt = ST_NORMAL;
         default:       nxt = state;
      endcase
      if (inv_hit)      nxt = ST_WAIT_IDLE;
      else if (arb_hit) nxt = ST_INHIBIT_TX;
      else if (crc_hit) nxt = ST_WAIT_SOF;
   end

   always_ff @(posedge clk) begin
      if (rst) state <= ST_WAIT_IDLE;
      else     state <= nxt;
   end

   assign tx_inhibit = (state == ST_WAIT_IDLE) || (state == ST_INHIBIT_TX);
   assign rx_enable  = (state == ST_NORMAL)    || (state == ST_INHIBIT_TX);
endmodule

// File: rtl/link_fault_supervisor.sv
module link_fault_supervisor
   import lfs_pkg::*;
#(
   parameter int CODE_W         = 8,
   parameter int CODE_CRC       = 'h14,
   parameter int CODE_ARB       = 'h18,
   parameter int CODE_INV       = 'h1C,
   parameter bit BREAK_ANY_TIME = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ev_break,
   input  logic              ev_bad_bit,
   input  logic              ev_frame_err,
   input  logic              ev_crc_err,
   input  logic              ev_tx_mismatch,
   input  logic              ev_phy_fault,
   input  logic              bus_idle,
   input  logic              sof_seen,
   input  logic              is_tx,
   input  logic              is_rx,
   input  logic              host_rd,
   output logic [CODE_W-1:0] vec_code,
   output logic              irq,
   output logic              tx_abort,
   output logic              tx_inhibit,
   output logic              rx_enable,
   output logic [1:0]        rec_state
);
   localparam int CODE_MAX = (1 << CODE_W) - 1;

   generate
      if (CODE_W < 2 || CODE_W > 16) begin : g_bad_w
         $error("CODE_W out of range");
      end
      if (CODE_CRC <= 0 || CODE_ARB <= 0 || CODE_INV <= 0 ||
          CODE_CRC > CODE_MAX || CODE_ARB > CODE_MAX || CODE_INV > CODE_MAX) begin : g_bad_code
         $error("state-vector codes must be non-zero and fit CODE_W");
      end
      if (CODE_CRC == CODE_ARB || CODE_ARB == CODE_INV || CODE_CRC == CODE_INV) begin : g_dup_code
         $error("state-vector codes must be distinct");
      end
   endgenerate

   logic [NUM_CLASS-1:0] cls_hit;
   logic                 abort_req;
   rec_state_e           st;

   lfs_classify #(.BREAK_ANY_TIME(BREAK_ANY_TIME)) u_cls (
      .ev_break       (ev_break),
      .ev_bad_bit     (ev_bad_bit),
      .ev_frame_err   (ev_frame_err),
      .ev_crc_err     (ev_crc_err),
      .ev_tx_mismatch (ev_tx_mismatch),
      .ev_phy_fault   (ev_phy_fault),
      .is_tx          (is_tx),
      .is_rx          (is_rx),
      .cls_hit        (cls_hit),
      .abort_req      (abort_req)
   );

   lfs_vector #(
      .CODE_W(CODE_W), .CODE_CRC(CODE_CRC), .CODE_ARB(CODE_ARB), .CODE_INV(CODE_INV)
   ) u_vec (
      .clk      (clk),
      .rst      (rst),
      .cls_hit  (cls_hit),
      .host_rd  (host_rd),
      .vec_code (vec_code),
      .irq      (irq)
   );

   lfs_recovery u_rec (
      .clk        (clk),
      .rst        (rst),
      .inv_hit    (cls_hit[CLS_INV]),
      .arb_hit    (cls_hit[CLS_ARB]),
      .crc_hit    (cls_hit[CLS_CRC]),
      .bus_idle   (bus_idle),
      .sof_seen   (sof_seen),
      .state      (st),
      .tx_inhibit (tx_inhibit),
      .rx_enable  (rx_enable)
   );

   always_ff @(posedge clk) begin
      if (rst) tx_abort <= 1'b0;
      else     tx_abort <= abort_req;
   end

   assign rec_state = st;
endmodule

// File: rtl/lfs_checker.sv
module lfs_checker #(
   parameter int CODE_W   = 8,
   parameter int CODE_INV = 'h1C
) (
   input logic              clk,
   input logic              rst,
   input logic              ev_break,
   input logic              ev_bad_bit,
   input logic              ev_frame_err,
   input logic              ev_crc_err,
   input logic              ev_tx_mismatch,
   input logic              ev_phy_fault,
   input logic              bus_idle,
   input logic              sof_seen,
   input logic              is_tx,
   input logic              is_rx,
   input logic              host_rd,
   input logic [CODE_W-1:0] vec_code,
   input logic              irq,
   input logic              tx_abort,
   input logic              tx_inhibit,
   input logic              rx_enable,
   input logic [1:0]        rec_state
);
   logic inv_ev;
   assign inv_ev = (ev_break & (is_tx | is_rx)) | ev_bad_bit | ev_frame_err | ev_phy_fault;

   p_break_vec_r2: assert property (@(posedge clk) disable iff (rst)
      ev_break && (is_tx || is_rx) |=> vec_code == CODE_W'(CODE_INV) && irq && rec_state == 2'd1);

   p_sof_exit_r3: assert property (@(posedge clk) disable iff (rst)
      rec_state == 2'd2 && sof_seen && !inv_ev && !ev_tx_mismatch && !ev_crc_err
      |=> rec_state == 2'd0);

   p_crc_wait_r4: assert property (@(posedge clk) disable iff (rst)
      ev_crc_err && !inv_ev && !ev_tx_mismatch |=> rec_state == 2'd2 && irq);

   p_mismatch_abort_r6: assert property (@(posedge clk) disable iff (rst)
      ev_tx_mismatch |=> tx_abort && tx_inhibit);

   p_irq_code_r8: assert property (@(posedge clk) disable iff (rst)
      irq == (vec_code != '0));

   p_read_clears_r9: assert property (@(posedge clk) disable iff (rst)
      host_rd && vec_code == CODE_W'(CODE_INV) && !inv_ev |=> vec_code != CODE_W'(CODE_INV));

   p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
      host_rd && ev_crc_err |=> irq);

   p_rx_gate_r12: assert property (@(posedge clk) disable iff (rst)
      rx_enable |-> (rec_state == 2'd0 || rec_state == 2'd3) && !(tx_inhibit && rec_state != 2'd3));

   logic unused_ok;
   assign unused_ok = bus_idle;
endmodule

bind link_fault_supervisor lfs_checker #(.CODE_W(CODE_W), .CODE_INV(CODE_INV)) u_chk (.*);

// File: tb/test_link_fault_supervisor.sv
module test_link_fault_supervisor;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ev_break = 0, ev_bad_bit = 0, ev_frame_err = 0, ev_crc_err = 0;
   logic ev_tx_mismatch = 0, ev_phy_fault = 0, bus_idle = 0, sof_seen = 0;
   logic is_tx = 0, is_rx = 0, host_rd = 0;
   logic [7:0] vec_code;
   logic irq, tx_abort, tx_inhibit, rx_enable;
   logic [1:0] rec_state;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   bit [2:0] mp;
   bit [1:0] ms;
   bit       mabort;

   always #(CLK_PERIOD/2) clk = ~clk;

   link_fault_supervisor i_link_fault_supervisor (.*);

   function automatic int code_of(bit [2:0] p);
      if (p[2]) return 'h1C;
      if (p[1]) return 'h18;
      if (p[0]) return 'h14;
      return 0;
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      chk(tag, "vec_code", int'(vec_code), code_of(mp));
      chk(tag, "irq", int'(irq), int'(mp != 0));
      chk(tag, "rec_state", int'(rec_state), int'(ms));
      chk(tag, "tx_abort", int'(tx_abort), int'(mabort));
      chk(tag, "tx_inhibit", int'(tx_inhibit), int'(ms == 1 || ms == 3));
      chk(tag, "rx_enable", int'(rx_enable), int'(ms == 0 || ms == 3));
   endtask

   // bits: 0 brk,1 badbit,2 frame,3 crc,4 txmis,5 phy,6 idle,7 sof,8 is_tx,9 is_rx,10 rd
   task automatic apply(bit [10:0] v, string tag);
      bit inv;
      bit [2:0] hit;
      {host_rd, is_rx, is_tx, sof_seen, bus_idle, ev_phy_fault, ev_tx_mismatch,
       ev_crc_err, ev_frame_err, ev_bad_bit, ev_break} = v;
      @(posedge clk);
      inv = (v[0] & (v[8] | v[9])) | v[1] | v[2] | v[5];
      hit = {inv, v[4], v[3]};
      if (v[10]) begin
         if (mp[2]) mp[2] = 0;
         else if (mp[1]) mp[1] = 0;
         else mp[0] = 0;
      end
      mp |= hit;
      if (inv) ms = 1;
      else if (v[4]) ms = 3;
      else if (v[3]) ms = 2;
      else if (ms == 1 && v[6]) ms = 2;
      else if (ms == 2 && v[7]) ms = 0;
      else if (ms == 3 && v[6]) ms = 0;
      mabort = v[4] | (v[8] & inv);
      @(negedge clk);
      check_all(tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1;
      {host_rd, is_rx, is_tx, sof_seen, bus_idle, ev_phy_fault, ev_tx_mismatch,
       ev_crc_err, ev_frame_err, ev_bad_bit, ev_break} = '0;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      rst = 0;
      mp = 0; ms = 1; mabort = 0;
      check_all("R1");
   endtask

   initial begin
      do_reset();
      // R3: sof ignored in wait-idle, then idle -> wait-sof -> normal
      apply(11'h080, "R3");
      apply(11'h040, "R3");
      apply(11'h080, "R3");
      // R2: break with no activity ignored; with receive active sets 0x1C
      apply(11'h001, "R2");
      apply(11'h201, "R2");
      apply(11'h400, "R9");
      // R5: framing error while transmitting aborts
      apply(11'h040, "R3"); apply(11'h080, "R3");
      apply(11'h104, "R5");
      apply(11'h002, "R5");
      // R6: transmit mismatch, inhibit until idle
      apply(11'h040, "R3"); apply(11'h080, "R3");
      apply(11'h110, "R6");
      apply(11'h000, "R6");
      apply(11'h040, "R6");
      // R4: crc -> wait-sof, no abort
      apply(11'h108, "R4");
      apply(11'h080, "R4");
      // R7: phy fault
      apply(11'h020, "R7");
      // R8, R9: read out all pending in priority order
      apply(11'h018, "R11");
      apply(11'h400, "R9"); apply(11'h400, "R9"); apply(11'h400, "R9");
      apply(11'h400, "R9");
      // R10: same-class set during read
      apply(11'h008, "R8");
      apply(11'h408, "R10");
      apply(11'h400, "R10");
      // R8, R11: exhaustive sweeps of all input combinations
      for (int i = 0; i < 2048; i++) apply(i[10:0], "R8");
      do_reset();
      for (int i = 0; i < 2048; i++) apply(11'((i * 1237 + 5) % 2048), "R11");
      do_reset();
      apply(11'h03F, "R11");
      apply(11'h7C0, "R12");
      apply(11'h7C0, "R12");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule